// File: doc/BRIEF.md
# Fuel-Gauge Register Bank with Command-Launched Reset

This block is the byte-wide register file of a battery fuel-gauge controller. A host reaches it through one address/data port: a write strobe with address and data, and a registered read path that returns the addressed byte one cycle later. It holds the magnitude-filter threshold, the learned capacity, the two bytes of available capacity, an inaccuracy counter and a flag byte. The programmed full capacity arrives on strapping pins and can be read back.

Writing the launch code `0x80` to the reset-command register (address `0x39`) while it holds `0x00` starts a software reset. A small sequencer steps through three states. `ST_IDLE` accepts host writes. `ST_LOAD` loads the defaults: learned capacity copied from the full-capacity pins, counters and the qualified flag cleared, the inaccurate and replaced flags set, and the high available byte either cleared or copied from the full capacity, as a configuration pin selects. `ST_FINISH` returns the command register to `0x00`. The transitions are fixed: `ST_IDLE` to `ST_LOAD` on the launch write, `ST_LOAD` to `ST_FINISH` always, and `ST_FINISH` to `ST_IDLE` always. A command write with any of the low seven bits set is refused and latches a sticky error flag. The synchronous hardware reset produces the same capacity and flag state as the software reset. It also restores the filter default and clears the error flag.

Top module: `gauge_regbank`

## Requirements
- R1: While `rst_i` is high the bank loads the following values. Learned capacity (0x05) is `full_cap_i`. Available low (0x02), counter (0x06) and command register (0x39) are 0. Available high (0x03) is `full_cap_i` when `hi_from_full_i` is 1 and 0 otherwise. Flags (0x07) are 0x03. The filter (0x0A) takes the parameter `FILT_INIT`. `rdata_o` is 0 and `busy_o` is 0.
- R2: The filter threshold at 0x0A is read-write, and a software reset leaves it unchanged.
- R3: A write of 0x80 to 0x39 in `ST_IDLE` starts a software reset. `busy_o` is high for exactly the two cycles after that write's clock edge.
- R4: The software reset loads the learned capacity (0x05) with the value of `full_cap_i`.
- R5: The software reset clears the available low byte, the counter and the qualified flag, and sets the inaccurate and replaced flags. It also clears the available high byte when `hi_from_full_i` is 0.
- R6: When `hi_from_full_i` is 1 at the load, the available high byte (0x03) takes `full_cap_i`.
- R7: In `ST_IDLE`, a write to 0x39 with any of bits 6..0 set sets the error flag (0x07 bit 7) and changes nothing else. The flag stays set through software resets and is cleared only by `rst_i`.
- R8: The command register reads 0x80 while the reset runs and 0x00 afterwards. A write of 0x00 to it is legal and has no effect.
- R9: Host writes are ignored while `busy_o` is high.
- R10: `rdata_o` returns, one cycle after the edge, the byte addressed at that edge. 0x08 reads `full_cap_i` and cannot be written. Unmapped addresses read 0 and ignore writes. 0x02, 0x03, 0x05 and 0x06 are read-write bytes.
- R11: The flag byte 0x07 holds inaccurate in bit 0, replaced in bit 1, qualified in bit 2 and error in bit 7, with zeros elsewhere. A host write updates only bits 0..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous hardware reset, active high |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register address for read and write |
| wdata_i | input | DATA_W | Write data |
| full_cap_i | input | DATA_W | Programmed full capacity from strapping |
| hi_from_full_i | input | 1 | Selects the reset default of the available high byte |
| rdata_o | output | DATA_W | Registered read data |
| busy_o | output | 1 | Software reset in progress |

## Verification
Read data is due one clock after the edge that samples the address, and it reflects the register contents before any write at that same edge. `busy_o` rises at the edge that accepts the launch write and falls two edges later. The reset values are visible to a read issued in the cycle after `ST_LOAD`, and the command register returns to zero after `ST_FINISH`. The bench drives inputs on the falling edge and predicts each edge with a behavioural model. It compares `rdata_o` and `busy_o` on the next falling edge, so every comparison lands in the cycle where these latencies place the result.

// File: rtl/gauge_pkg.sv
package gauge_pkg;

    localparam int unsigned ADR_AVAIL_LO = 'h02;
    localparam int unsigned ADR_AVAIL_HI = 'h03;
    localparam int unsigned ADR_LEARNED  = 'h05;
    localparam int unsigned ADR_INACC    = 'h06;
    localparam int unsigned ADR_FLAGS    = 'h07;
    localparam int unsigned ADR_FULLCAP  = 'h08;
    localparam int unsigned ADR_FILTER   = 'h0A;
    localparam int unsigned ADR_COMMAND  = 'h39;

    localparam int unsigned FB_INACC = 0;
    localparam int unsigned FB_REPL  = 1;
    localparam int unsigned FB_QUAL  = 2;
    localparam int unsigned FB_ERR   = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_FINISH = 2'd2
    } rst_state_e;

endpackage

// File: rtl/gauge_rst_ctrl.sv
module gauge_rst_ctrl
    import gauge_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              load_o,
    output logic              busy_o,
    output logic              illegal_o,
    output logic [DATA_W-1:0] cmd_o
);

    localparam logic [DATA_W-1:0] LAUNCH = DATA_W'(1) << (DATA_W - 1);

    rst_state_e        state_q, state_d;
    logic [DATA_W-1:0] cmd_q;
    logic              cmd_hit, launch;

    assign cmd_hit = wr_en_i && (addr_i == ADDR_W'(ADR_COMMAND));
    assign launch  = cmd_hit && (state_q == ST_IDLE) && (cmd_q == '0)
                     && (wdata_i == LAUNCH);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cmd_q <= '0;
        end else if (launch) begin
            cmd_q <= LAUNCH;
        end else if (state_q == ST_FINISH) begin
            cmd_q <= '0;
        end
    end

    always_comb begin
        load_o    = 1'b0;
        busy_o    = 1'b1;
        illegal_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                illegal_o = cmd_hit && (wdata_i[DATA_W-2:0] != '0);
            end
            ST_LOAD:   load_o = 1'b1;
            ST_FINISH: load_o = 1'b0;
            default:   busy_o = 1'b0;
        endcase
    end

    assign cmd_o = cmd_q;

    a_r3_launch_loads: assert property (@(posedge clk_i) disable iff (rst_i)
        launch |=> (load_o && busy_o));
    a_r3_busy_two_cycles: assert property (@(posedge clk_i) disable iff (rst_i)
        load_o |=> (busy_o && !load_o));
    a_r7_illegal_no_launch: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |=> (state_q == ST_IDLE && cmd_q == '0));
    a_r8_cmd_cleared: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_FINISH) |=> (cmd_q == '0 && !busy_o));

endmodule

// File: rtl/gauge_regfile.sv
module gauge_regfile
    import gauge_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [DATA_W-1:0] FILT_INIT = 8'h12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_ok_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              load_i,
    input  logic              illegal_i,
    input  logic [DATA_W-1:0] full_cap_i,
    input  logic              hi_from_full_i,
    output logic [DATA_W-1:0] filt_o,
    output logic [DATA_W-1:0] learned_o,
    output logic [DATA_W-1:0] avail_lo_o,
    output logic [DATA_W-1:0] avail_hi_o,
    output logic [DATA_W-1:0] inacc_o,
    output logic [DATA_W-1:0] flags_o
);

    localparam int NFLAG = 3;
    localparam logic [NFLAG-1:0] FLAG_DEFAULT = 3'b011;

    logic [DATA_W-1:0] filt_q, learned_q, lo_q, hi_q, inacc_q;
    logic [NFLAG-1:0]  flag_q;
    logic              err_q;
    logic              reload;

    assign reload = rst_i || load_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            filt_q <= FILT_INIT;
        end else if (wr_ok_i && addr_i == ADDR_W'(ADR_FILTER)) begin
            filt_q <= wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (reload) begin
            learned_q <= full_cap_i;
            lo_q      <= '0;
            hi_q      <= hi_from_full_i ? full_cap_i : '0;
            inacc_q   <= '0;
        end else if (wr_ok_i) begin
            if (addr_i == ADDR_W'(ADR_LEARNED))  learned_q <= wdata_i;
            if (addr_i == ADDR_W'(ADR_AVAIL_LO)) lo_q      <= wdata_i;
            if (addr_i == ADDR_W'(ADR_AVAIL_HI)) hi_q      <= wdata_i;
            if (addr_i == ADDR_W'(ADR_INACC))    inacc_q   <= wdata_i;
        end
    end

    for (genvar b = 0; b < NFLAG; b++) begin : g_flag
        always_ff @(posedge clk_i) begin
            if (reload) begin
                flag_q[b] <= FLAG_DEFAULT[b];
            end else if (wr_ok_i && addr_i == ADDR_W'(ADR_FLAGS)) begin
                flag_q[b] <= wdata_i[b];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            err_q <= 1'b0;
        end else if (illegal_i) begin
            err_q <= 1'b1;
        end
    end

    always_comb begin
        flags_o          = '0;
        flags_o[FB_INACC] = flag_q[0];
        flags_o[FB_REPL]  = flag_q[1];
        flags_o[FB_QUAL]  = flag_q[2];
        flags_o[FB_ERR]   = err_q;
    end

    assign filt_o     = filt_q;
    assign learned_o  = learned_q;
    assign avail_lo_o = lo_q;
    assign avail_hi_o = hi_q;
    assign inacc_o    = inacc_q;

    a_r4_learned_copy: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (learned_q == $past(full_cap_i)));
    a_r5_defaults: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (lo_q == '0 && inacc_q == '0 && flag_q == 3'b011));
    a_r6_high_from_full: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && hi_from_full_i) |=> (hi_q == $past(full_cap_i)));
    a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        err_q |=> err_q);
    a_r2_filter_kept: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> $stable(filt_q));

endmodule

// File: rtl/gauge_rd_mux.sv
module gauge_rd_mux
    import gauge_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] filt_i,
    input  logic [DATA_W-1:0] learned_i,
    input  logic [DATA_W-1:0] avail_lo_i,
    input  logic [DATA_W-1:0] avail_hi_i,
    input  logic [DATA_W-1:0] inacc_i,
    input  logic [DATA_W-1:0] flags_i,
    input  logic [DATA_W-1:0] full_cap_i,
    input  logic [DATA_W-1:0] cmd_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (addr_i == ADDR_W'(ADR_AVAIL_LO)) sel = avail_lo_i;
        if (addr_i == ADDR_W'(ADR_AVAIL_HI)) sel = avail_hi_i;
        if (addr_i == ADDR_W'(ADR_LEARNED))  sel = learned_i;
        if (addr_i == ADDR_W'(ADR_INACC))    sel = inacc_i;
        if (addr_i == ADDR_W'(ADR_FLAGS))    sel = flags_i;
        if (addr_i == ADDR_W'(ADR_FULLCAP))  sel = full_cap_i;
        if (addr_i == ADDR_W'(ADR_FILTER))   sel = filt_i;
        if (addr_i == ADDR_W'(ADR_COMMAND))  sel = cmd_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_o <= '0;
        end else begin
            rdata_o <= sel;
        end
    end

    a_r10_read_registered: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (rdata_o == $past(sel)));

endmodule

// File: rtl/gauge_regbank.sv
module gauge_regbank
    import gauge_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [DATA_W-1:0] FILT_INIT = 8'h12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] full_cap_i,
    input  logic              hi_from_full_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o
);

    logic              load_w, busy_w, illegal_w, wr_ok;
    logic [DATA_W-1:0] cmd_w, filt_w, learned_w, lo_w, hi_w, inacc_w, flags_w;

    gauge_rst_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .load_o    (load_w),
        .busy_o    (busy_w),
        .illegal_o (illegal_w),
        .cmd_o     (cmd_w)
    );

    assign wr_ok = wr_en_i && !busy_w;

    gauge_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FILT_INIT(FILT_INIT)) u_regs (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .wr_ok_i        (wr_ok),
        .addr_i         (addr_i),
        .wdata_i        (wdata_i),
        .load_i         (load_w),
        .illegal_i      (illegal_w),
        .full_cap_i     (full_cap_i),
        .hi_from_full_i (hi_from_full_i),
        .filt_o         (filt_w),
        .learned_o      (learned_w),
        .avail_lo_o     (lo_w),
        .avail_hi_o     (hi_w),
        .inacc_o        (inacc_w),
        .flags_o        (flags_w)
    );

    gauge_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .addr_i     (addr_i),
        .filt_i     (filt_w),
        .learned_i  (learned_w),
        .avail_lo_i (lo_w),
        .avail_hi_i (hi_w),
        .inacc_i    (inacc_w),
        .flags_i    (flags_w),
        .full_cap_i (full_cap_i),
        .cmd_i      (cmd_w),
        .rdata_o    (rdata_o)
    );

    assign busy_o = busy_w;

    a_r9_busy_writes_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_w && !load_w) |=> ($stable(filt_w) && $stable(learned_w) && $stable(lo_w)
                                 && $stable(hi_w) && $stable(inacc_w)));
    a_r7_illegal_keeps_bytes: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_w |=> ($stable(learned_w) && $stable(lo_w) && $stable(hi_w) && $stable(filt_w)));

endmodule

// File: tb/gauge_regbank_test.sv
`timescale 1ns/1ps
module gauge_regbank_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] full_cap = 8'h5A;
    logic       hi_sel = 1'b0;
    logic [7:0] rdata;
    logic       busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural model state
    int m_filt, m_learn, m_lo, m_hi, m_cnt, m_ci, m_br, m_dq, m_err, m_cmd, m_phase;

    always #2 clk = ~clk;

    gauge_regbank #(.DATA_W(8), .ADDR_W(8), .FILT_INIT(8'h12)) uut (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .full_cap_i(full_cap), .hi_from_full_i(hi_sel), .rdata_o(rdata), .busy_o(busy)
    );

    function automatic int model_read(int a);
        case (a)
            'h02: return m_lo;
            'h03: return m_hi;
            'h05: return m_learn;
            'h06: return m_cnt;
            'h07: return (m_err << 7) | (m_dq << 2) | (m_br << 1) | m_ci;
            'h08: return int'(full_cap);
            'h0A: return m_filt;
            'h39: return m_cmd;
            default: return 0;
        endcase
    endfunction

    task automatic model_defaults();
        m_learn = int'(full_cap);
        m_lo = 0; m_cnt = 0; m_dq = 0; m_ci = 1; m_br = 1;
        m_hi = hi_sel ? int'(full_cap) : 0;
    endtask

    task automatic model_edge(bit r, bit w, int a, int d);
        if (r) begin
            model_defaults();
            m_filt = 'h12; m_err = 0; m_cmd = 0; m_phase = 0;
        end else if (m_phase == 1) begin
            model_defaults();
            m_phase = 2;
        end else if (m_phase == 2) begin
            m_cmd = 0; m_phase = 0;
        end else if (w) begin
            case (a)
                'h02: m_lo = d;
                'h03: m_hi = d;
                'h05: m_learn = d;
                'h06: m_cnt = d;
                'h07: begin m_ci = d & 1; m_br = (d >> 1) & 1; m_dq = (d >> 2) & 1; end
                'h0A: m_filt = d;
                'h39: begin
                    if (d == 'h80) begin m_cmd = 'h80; m_phase = 1; end
                    else if ((d & 'h7F) != 0) m_err = 1;
                end
                default: ;
            endcase
        end
    endtask

    task automatic check(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // one cycle: drive at falling edge, predict, compare at next falling edge
    task automatic step(bit r, bit w, int a, int d, string tag);
        int exp_rd;
        rst = r; wr_en = w; addr = 8'(a); wdata = 8'(d);
        exp_rd = r ? 0 : model_read(a);
        model_edge(r, w, a, d);
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(rdata), exp_rd);
        check("R3 busy", int'(busy), (m_phase != 0) ? 1 : 0);
    endtask

    task automatic rd(int a, string tag);
        step(0, 0, a, 0, tag);
    endtask

    task automatic wr(int a, int d, string tag);
        step(0, 1, a, d, tag);
    endtask

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0, "R1 reset");
        step(1, 0, 0, 0, "R1 reset");
        rd('h05, "R1 learned"); rd('h02, "R1 low"); rd('h03, "R1 high");
        rd('h06, "R1 counter"); rd('h07, "R1 flags"); rd('h0A, "R1 filter");
        rd('h39, "R1 command");
        wr('h0A, 'h33, "R2 filter write"); rd('h0A, "R2 filter read");
        wr('h05, 'h11, "R10 learned"); wr('h02, 'h22, "R10 low");
        wr('h03, 'h44, "R10 high"); wr('h06, 'h09, "R10 counter");
        wr('h07, 'hFC, "R11 flag write");
        rd('h07, "R11 flag layout"); rd('h05, "R10 learned read");
        wr('h39, 'h00, "R8 zero write"); rd('h39, "R8 zero readback"); rd('h05, "R8 no effect");
        wr('h39, 'h81, "R7 illegal"); rd('h07, "R7 error flag"); rd('h05, "R7 unchanged");
        rd('h03, "R7 unchanged high");
        wr('h39, 'h80, "R3 launch");
        rd('h39, "R8 command busy");
        wr('h05, 'h77, "R9 write while busy");
        rd('h05, "R4 learned copy"); rd('h02, "R5 low"); rd('h03, "R5 high");
        rd('h06, "R5 counter"); rd('h07, "R5 R7 flags"); rd('h0A, "R2 filter kept");
        rd('h39, "R8 command cleared");
        hi_sel = 1'b1; full_cap = 8'hC3;
        wr('h39, 'h80, "R6 launch");
        rd('h03, "R6 busy"); rd('h03, "R6 busy"); rd('h03, "R6 high copy");
        rd('h08, "R10 full readback");
        wr('h08, 'h01, "R10 read-only"); rd('h08, "R10 read-only");
        wr('h10, 'h55, "R10 unmapped"); rd('h10, "R10 unmapped");
        step(1, 0, 0, 0, "R1 hw reset");
        rd('h07, "R1 R7 error cleared"); rd('h03, "R1 R6 high"); rd('h0A, "R1 filter");
        for (int i = 0; i < 3000; i++) begin
            int pick, a, d;
            pick = $urandom_range(0, 9);
            case (pick)
                0: a = 'h02; 1: a = 'h03; 2: a = 'h05; 3: a = 'h06; 4: a = 'h07;
                5: a = 'h08; 6: a = 'h0A; 7: a = 'h39; 8: a = 'h39; default: a = 'h21;
            endcase
            d = $urandom_range(0, 255);
            if (a == 'h39 && d[0]) d = 'h80;
            if ($urandom_range(0, 7) == 0) begin
                hi_sel = 1'($urandom_range(0, 1));
                full_cap = 8'($urandom_range(0, 255));
            end
            step($urandom_range(0, 99) == 0, $urandom_range(0, 1) == 1, a, d, "R10 R11 random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule